// File: doc/BRIEF.md
# Emergency Output Shutdown Controller

This block takes a group of motor-drive outputs off the bus in an emergency. Each channel keeps a shutdown flag. The flag is set in one of two ways: software writes a one-shot trigger, or a chosen edge arrives on that channel's external fault input. While the flag is set, every output-enable bit of the channel is held low, so the pins float. Only a valid one-shot release written by software clears the flag again. A channel that is switched off always holds its flag at zero.

Software reaches each channel through one control word. It writes the word through a simple write port and reads it back through a combinational read port. The write address picks the channel. The control word holds these fields:

| Bit | Field | Read back |
|-----|-------|-----------|
| 0 | channel on | stored value |
| 1 | release-guard mode | stored value |
| 2 | rising-edge select | stored value |
| 3 | falling-edge select | stored value |
| 4 | trigger strobe | always 0 |
| 5 | release strobe | always 0 |
| 6 | shutdown flag | status only |

Each fault input passes through a two-stage synchronizer before edge detection. The number of channels is set by `NCH` and the number of pins per channel by `PINS`.

Top module: `hzsd_top`

## Requirements
- R1: After reset, every channel reads back 0 and every bit of `outEn` is 1.
- R2: A write to a channel with bit 0 = 1, bit 4 = 1 and bit 5 = 0 sets that channel's flag (read bit 6) at the write's clock edge.
- R3: Each channel's `outEn` slice (`outEn[ch*PINS +: PINS]`) is all zeros exactly one clock after the flag is 1, and all ones one clock after the flag is 0.
- R4: A write with bit 0 = 1, bit 5 = 1 and bit 4 = 0 clears the flag, subject to R8 and R10.
- R5: Reading a channel returns bits 0 to 3 as last written, bit 6 as the flag, and 0 in bits 4 and 5.
- R6: While the channel-on bit is 0, a write of 1 to the trigger or release strobe has no effect, and the flag is held at 0. A write with bit 0 = 0 clears the flag at that edge.
- R7: With the channel on, a synchronized edge of the fault input sets the flag if its polarity is selected: bit 2 selects rising edges and bit 3 selects falling edges. With both bits set, either edge counts. An unselected edge has no effect. The flag is set on the third rising clock edge after the input changes.
- R8: With bit 1 = 1, a release is ignored while the fault input is at an abnormal level. A high level is abnormal when bit 2 is set, and a low level is abnormal when bit 3 is set. With bit 1 = 0, a release works whatever the fault level is.
- R9: A write with both bit 4 and bit 5 set does nothing to the flag.
- R10: A selected fault edge in the same cycle as a release write wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control word |
| wrAddr | input | AW | Channel selected by the write |
| wrData | input | 6 | Control word data, bits 0 to 5 |
| rdAddr | input | AW | Channel selected by the read |
| rdData | output | 7 | Control word and flag of the read channel |
| faultIn | input | NCH | Asynchronous fault input, one per channel |
| outEn | output | NCH*PINS | Output enables, `PINS` bits per channel |

## Verification
Two events can fall in the same clock: a synchronized fault edge, and a software release aimed at a flag that is already set. To provoke this, the bench toggles the fault input on a falling clock edge. It then waits through the two synchronizer stages and issues the release write in the exact cycle in which the edge detector fires. The check passes if the flag is still set afterwards. A second collision is also checked: a write that raises the trigger and release bits together must leave the flag unchanged, both when the flag is set and when it is clear.

// File: rtl/hzsd_pkg.sv
package hzsd_pkg;
  // Bit positions of the per-channel control word
  localparam int BIT_EN   = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_RISE = 2;
  localparam int BIT_FALL = 3;
  localparam int BIT_TRIG = 4;
  localparam int BIT_CLR  = 5;
  localparam int BIT_FLAG = 6;

  localparam int WR_W = 6;
  localparam int RD_W = 7;

  // Stored configuration of one channel
  typedef struct packed {
    logic en;
    logic mode;
    logic selRise;
    logic selFall;
  } hzCfg_t;

  // Strobes from the control to the datapath, valid for a single cycle
  typedef struct packed {
    logic enNow;
    logic modeNow;
    logic trig;
    logic clr;
  } hzStb_t;
endpackage

// File: rtl/hzsd_sync.sv
module hzsd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hzsd_ctrl.sv
module hzsd_ctrl
  import hzsd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [AW-1:0]         wrAddr,
  input  logic [WR_W-1:0]       wrData,
  input  logic [AW-1:0]         rdAddr,
  input  logic [NCH-1:0]        flagVec,
  output hzCfg_t [NCH-1:0]      cfgVec,
  output hzStb_t [NCH-1:0]      stbVec,
  output logic [RD_W-1:0]       rdData
);
  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      logic   hit;
      hzCfg_t cfgQ;
      logic   wantTrig;
      logic   wantClr;

      assign hit      = wrEn && (wrAddr == AW'(ch));
      assign wantTrig = wrData[BIT_TRIG];
      assign wantClr  = wrData[BIT_CLR];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cfgQ <= '0;
        end else if (hit) begin
          cfgQ.en      <= wrData[BIT_EN];
          cfgQ.mode    <= wrData[BIT_MODE];
          cfgQ.selRise <= wrData[BIT_RISE];
          cfgQ.selFall <= wrData[BIT_FALL];
        end
      end

      // A write acts with the enable and mode it carries itself
      always_comb begin
        stbVec[ch].enNow   = hit ? wrData[BIT_EN]   : cfgQ.en;
        stbVec[ch].modeNow = hit ? wrData[BIT_MODE] : cfgQ.mode;
        // Both strobes at once is an illegal access and does nothing
        stbVec[ch].trig    = hit && wrData[BIT_EN] && wantTrig && !wantClr;
        stbVec[ch].clr     = hit && wrData[BIT_EN] && wantClr  && !wantTrig;
      end

      assign cfgVec[ch] = cfgQ;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rdAddr == AW'(i)) begin
        rdData[BIT_EN]   = cfgVec[i].en;
        rdData[BIT_MODE] = cfgVec[i].mode;
        rdData[BIT_RISE] = cfgVec[i].selRise;
        rdData[BIT_FALL] = cfgVec[i].selFall;
        rdData[BIT_FLAG] = flagVec[i];
      end
    end
  end
endmodule

// File: rtl/hzsd_chan.sv
module hzsd_chan
  import hzsd_pkg::*;
#(
  parameter int PINS      = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            selRise,
  input  logic            selFall,
  input  hzStb_t          stb,
  input  logic            faultIn,
  output logic            flag,
  output logic [PINS-1:0] outEn
);
  logic faultSync;
  logic faultPrev;
  logic faultEdge;
  logic faultActive;
  logic flagQ;
  logic flagNext;

  hzsd_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (faultIn),
    .dout (faultSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultPrev <= 1'b0;
    else       faultPrev <= faultSync;
  end

  assign faultEdge   = stb.enNow &&
                       ((selRise &&  faultSync && !faultPrev) ||
                        (selFall && !faultSync &&  faultPrev));
  assign faultActive = (selRise && faultSync) || (selFall && !faultSync);

  // Priority: disable, fault edge, trigger, guarded release, hold
  always_comb begin
    flagNext = flagQ;
    if (!stb.enNow)
      flagNext = 1'b0;
    else if (faultEdge)
      flagNext = 1'b1;
    else if (stb.trig)
      flagNext = 1'b1;
    else if (stb.clr && !(stb.modeNow && faultActive))
      flagNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= flagNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outEn <= '1;
    else       outEn <= {PINS{~flagQ}};
  end

  assign flag = flagQ;
endmodule

// File: rtl/hzsd_top.sv
module hzsd_top
  import hzsd_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int PINS = 3,
  localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [AW-1:0]         wrAddr,
  input  logic [WR_W-1:0]       wrData,
  input  logic [AW-1:0]         rdAddr,
  output logic [RD_W-1:0]       rdData,
  input  logic [NCH-1:0]        faultIn,
  output logic [NCH*PINS-1:0]   outEn
);
  hzCfg_t [NCH-1:0] cfgVec;
  hzStb_t [NCH-1:0] stbVec;
  logic   [NCH-1:0] flagVec;

  hzsd_ctrl #(.NCH(NCH), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .flagVec (flagVec),
    .cfgVec  (cfgVec),
    .stbVec  (stbVec),
    .rdData  (rdData)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chan
      hzsd_chan #(.PINS(PINS)) u_chan (
        .clk     (clk),
        .rstN    (rstN),
        .selRise (cfgVec[ch].selRise),
        .selFall (cfgVec[ch].selFall),
        .stb     (stbVec[ch]),
        .faultIn (faultIn[ch]),
        .flag    (flagVec[ch]),
        .outEn   (outEn[ch*PINS +: PINS])
      );
    end
  endgenerate
endmodule

// File: rtl/hzsd_chk.sv
module hzsd_chk
  import hzsd_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int PINS = 3,
  parameter int AW   = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [AW-1:0]       wrAddr,
  input logic [WR_W-1:0]     wrData,
  input logic [RD_W-1:0]     rdData,
  input logic [NCH-1:0]      flagVec,
  input logic [NCH*PINS-1:0] outEn
);
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BIT_CLR:BIT_TRIG] == 2'b00); // R5

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && wrAddr == AW'(i) && wrData[BIT_EN] && wrData[BIT_TRIG] && !wrData[BIT_CLR])
        |=> flagVec[i]); // R2

      AST_OFF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && wrAddr == AW'(i) && !wrData[BIT_EN]) |=> !flagVec[i]); // R6

      AST_PINS_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
        flagVec[i] |=> (outEn[i*PINS +: PINS] == '0)); // R3

      AST_PINS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
        !flagVec[i] |=> (outEn[i*PINS +: PINS] == '1)); // R3
    end
  endgenerate
endmodule

bind hzsd_top hzsd_chk #(.NCH(NCH), .PINS(PINS), .AW(AW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .rdData  (rdData),
  .flagVec (flagVec),
  .outEn   (outEn)
);

// File: tb/hzsd_top_tb.sv
module hzsd_top_tb;
  localparam int NCH  = 2;
  localparam int PINS = 3;

  logic                clk = 1'b0;
  logic                rstN;
  logic                wrEn;
  logic [0:0]          wrAddr;
  logic [5:0]          wrData;
  logic [0:0]          rdAddr;
  logic [6:0]          rdData;
  logic [NCH-1:0]      faultIn;
  logic [NCH*PINS-1:0] outEn;

  int nTests = 0;
  int nFail  = 0;

  hzsd_top #(.NCH(NCH), .PINS(PINS)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .faultIn(faultIn), .outEn(outEn)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input int ch, input int data);
    wrAddr = ch[0:0];
    wrData = data[5:0];
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic rd(input string tag, input int ch, input int exp);
    rdAddr = ch[0:0];
    #1;
    check(tag, int'(rdData), exp);
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 outEn", int'(outEn), 6'h3F);
    rd("R1 ch0", 0, 0);
    rd("R1 ch1", 1, 0);
  endtask

  task automatic t_trigger;
    wr(0, 6'h11);
    rd("R2 trig sets flag", 0, 7'h41);
    check("R3 outEn one cycle late", int'(outEn[2:0]), 3'b111);
    waitN(1);
    check("R3 outEn floats", int'(outEn[2:0]), 3'b000);
    check("R2 other channel", int'(outEn[5:3]), 3'b111);
  endtask

  task automatic t_clear;
    wr(0, 6'h21);
    rd("R4 clear", 0, 7'h01);
    waitN(1);
    check("R3 outEn drives", int'(outEn[2:0]), 3'b111);
  endtask

  task automatic t_disabled;
    wr(1, 6'h10);
    rd("R6 trig while off", 1, 0);
    waitN(1);
    check("R6 outEn while off", int'(outEn[5:3]), 3'b111);
    wr(0, 6'h11);
    rd("R6 setup", 0, 7'h41);
    wr(0, 6'h00);
    rd("R6 off clears flag", 0, 0);
    wr(0, 6'h01);
    rd("R6 flag stays clear", 0, 7'h01);
  endtask

  task automatic t_both;
    wr(0, 6'h11);
    wr(0, 6'h31);
    rd("R9 both strobes, flag set", 0, 7'h41);
    wr(0, 6'h21);
    wr(0, 6'h31);
    rd("R9 both strobes, flag clear", 0, 7'h01);
  endtask

  task automatic t_fault_rise;
    wr(0, 6'h05);
    faultIn[0] = 1'b1;
    waitN(2);
    rd("R7 sync latency", 0, 7'h05);
    waitN(1);
    rd("R7 rising edge", 0, 7'h45);
    wr(0, 6'h25);
    rd("R8 mode0 release while high", 0, 7'h05);
    faultIn[0] = 1'b0;
    waitN(4);
    rd("R7 unselected fall", 0, 7'h05);
  endtask

  task automatic t_fault_fall;
    wr(0, 6'h0B);
    faultIn[0] = 1'b1;
    waitN(4);
    rd("R7 unselected rise", 0, 7'h0B);
    faultIn[0] = 1'b0;
    waitN(3);
    rd("R7 falling edge", 0, 7'h4B);
    wr(0, 6'h2B);
    rd("R8 guarded release blocked", 0, 7'h4B);
    faultIn[0] = 1'b1;
    waitN(4);
    rd("R8 flag held", 0, 7'h4B);
    wr(0, 6'h2B);
    rd("R8 guarded release allowed", 0, 7'h0B);
  endtask

  task automatic t_both_edges;
    wr(1, 6'h0D);
    faultIn[1] = 1'b1;
    waitN(3);
    rd("R7 both sel, rise", 1, 7'h4D);
    wr(1, 6'h2D);
    rd("R7 release", 1, 7'h0D);
    faultIn[1] = 1'b0;
    waitN(3);
    rd("R7 both sel, fall", 1, 7'h4D);
    wr(1, 6'h2D);
    rd("R7 release again", 1, 7'h0D);
  endtask

  task automatic t_collision;
    faultIn[0] = 1'b0;
    waitN(4);
    wr(0, 6'h15);
    rd("R10 setup", 0, 7'h45);
    faultIn[0] = 1'b1;
    waitN(2);
    wr(0, 6'h25);
    rd("R10 edge beats release", 0, 7'h45);
    wr(0, 6'h25);
    rd("R10 later release", 0, 7'h05);
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0; faultIn = '0;
    waitN(2);
    t_reset;
    rstN = 1'b1;
    waitN(1);
    t_reset;
    t_trigger;
    t_clear;
    t_disabled;
    t_both;
    t_fault_rise;
    t_fault_fall;
    t_both_edges;
    t_collision;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule